// File: doc/BRIEF.md
# Safe-Read 64-bit Timestamp Counter

This block keeps a 64-bit time counter that advances by one on every microsecond tick and is reached over a 32-bit word interface. Software can load a new value with two word writes. It can clear the counter with a control write that flips an internal request flag. It can also read either half of the counter directly, one word at a time.

A separate merge port can force the counter to a new value in any cycle. Because of this, two plain word reads may come from different moments in time.

The snapshot engine solves this. It samples the upper half, then the lower half, then the upper half again, one sample per clock. If the two upper samples differ, it repeats the lower/upper pair against the newer upper value. It stops after a bounded number of pairs and raises a warning if it never saw a match. The result is a coherent 64-bit value delivered with a one-cycle valid pulse.

Top module: `stamp_counter`

## Requirements
- R1: After reset the counter, the staged lower word and the request flag are zero, `regRdData` is zero, and `snapValid` and `snapWarn` are low.
- R2: With no jump and no register write, each clock edge with `usTick` high adds one to the 64-bit counter, carrying from bit 31 into bit 32. With `usTick` low the counter holds.
- R3: A write to address 0 stores the data in a staging register and leaves the counter unchanged. A write to address 1 loads the counter with {write data, staged lower word} on that same edge.
- R4: A write to address 2 with bit 0 set clears the counter and inverts the request flag, so two such writes return the flag to 0. A write to address 2 with bit 0 clear changes neither.
- R5: When `jumpEn` is high, the counter takes `jumpValue` on that edge, ahead of any tick, load or clear in the same cycle.
- R6: A read strobe captures a word into `regRdData` on its edge and holds it until the next strobe. Address 0 gives counter bits 31:0 and address 1 gives bits 63:32. Address 2 gives the request flag in bit 0 with zeros above. Address 3 gives zero. The counter value used is the one from before that edge.
- R7: When idle, `snapReq` starts a snapshot. The upper word is sampled on the request edge, the lower word one edge later, and the upper word again on the edge after that. If the two upper samples match, `snapValid` is high after that third edge, and `snapData` is {upper, lower}.
- R8: When the two upper samples differ, the engine keeps the newer upper sample and samples another lower/upper pair on the next two edges. Each retry therefore adds two cycles.
- R9: After MAX_TRIES lower/upper pairs (default 10) with no match, the engine finishes with `snapWarn` high. `snapData` then holds {last upper sample, last lower sample}, and `snapValid` is high 2*MAX_TRIES+1 edges after the request.
- R10: A `snapReq` that arrives while a snapshot is in progress is ignored. It neither restarts the sequence nor produces an extra result.
- R11: `snapValid` is a single-cycle pulse, and `snapWarn` is high only together with `snapValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usTick | input | 1 | Microsecond tick, one-cycle pulse |
| regWrEn | input | 1 | Word write strobe |
| regRdEn | input | 1 | Word read strobe |
| regAddr | input | 2 | Word address (0 lower, 1 upper, 2 control) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, registered |
| jumpEn | input | 1 | Merge update strobe |
| jumpValue | input | 64 | Merge update value |
| snapReq | input | 1 | Start a coherent snapshot |
| snapData | output | 64 | Coherent snapshot result |
| snapValid | output | 1 | Snapshot result pulse |
| snapWarn | output | 1 | Retry bound reached, with `snapValid` |

## Verification
The bound assertions check the following counter rules on every cycle:
- the effect of a tick, a hold, a staged lower write, an upper commit, a clear and a jump on the counter;
- the single-cycle shape of `snapValid` and its pairing with `snapWarn`.

The retry behaviour can only be shown by the bench scenarios, because it depends on what the counter did across several cycles. These scenarios cover:
- a carry out of the lower word in the middle of a read, which costs one extra pair;
- jumps on every cycle, which exhaust the bound;
- a repeated request while the engine is busy.

A bench model of the counter rebuilds the expected data, the latency and the warning from the sampled history.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LO  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;

  typedef enum logic [1:0] {
    SNAP_IDLE = 2'd0,
    SNAP_LO   = 2'd1,
    SNAP_HI   = 2'd2
  } snap_state_t;

  typedef struct packed {
    logic capHi;   // latch upper word as reference
    logic capLo;   // latch lower word
    logic finish;  // publish result
    logic warn;    // publish with bound-reached flag
  } snap_strobe_t;
endpackage

// File: rtl/stamp_dp.sv
module stamp_dp
  import stamp_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   usTick,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [CNT_W/2-1:0]     regWrData,
  input  logic                   jumpEn,
  input  logic [CNT_W-1:0]       jumpValue,
  input  snap_strobe_t           strobes,
  output logic                   hiMatch,
  output logic [CNT_W-1:0]       cntNow,
  output logic [CNT_W/2-1:0]     regRdData,
  output logic [CNT_W-1:0]       snapData,
  output logic                   snapValid,
  output logic                   snapWarn
);
  localparam int unsigned WORD_W = CNT_W / 2;

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shadowLo;
  logic [WORD_W-1:0] refHi;
  logic [WORD_W-1:0] seenLo;
  logic              rstReq;
  logic              wrLo, wrHi, clrHit;
  logic [WORD_W-1:0] rdMux;

  assign wrLo   = regWrEn && (regAddr == ADDR_LO);
  assign wrHi   = regWrEn && (regAddr == ADDR_HI);
  assign clrHit = regWrEn && (regAddr == ADDR_CTL) && regWrData[0];

  // counter: jump beats load beats clear beats tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (jumpEn) begin
      cnt <= jumpValue;
    end else if (wrHi) begin
      cnt <= {regWrData, shadowLo};
    end else if (clrHit) begin
      cnt <= '0;
    end else if (usTick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowLo <= '0;
      rstReq   <= 1'b0;
    end else begin
      if (wrLo)   shadowLo <= regWrData;
      if (clrHit) rstReq   <= ~rstReq;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_LO:  rdMux = cnt[WORD_W-1:0];
      ADDR_HI:  rdMux = cnt[CNT_W-1:WORD_W];
      ADDR_CTL: rdMux = {{(WORD_W-1){1'b0}}, rstReq};
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

  // snapshot capture registers
  assign hiMatch = (cnt[CNT_W-1:WORD_W] == refHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refHi     <= '0;
      seenLo    <= '0;
      snapData  <= '0;
      snapValid <= 1'b0;
      snapWarn  <= 1'b0;
    end else begin
      if (strobes.capHi)  refHi    <= cnt[CNT_W-1:WORD_W];
      if (strobes.capLo)  seenLo   <= cnt[WORD_W-1:0];
      if (strobes.finish) snapData <= {cnt[CNT_W-1:WORD_W], seenLo};
      snapValid <= strobes.finish;
      snapWarn  <= strobes.finish && strobes.warn;
    end
  end

  assign cntNow = cnt;
endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter int unsigned MAX_TRIES = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         snapReq,
  input  logic         hiMatch,
  output snap_strobe_t strobes
);
  localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  snap_state_t      state, nState;
  logic [TRY_W-1:0] tries, nTries;

  always_comb begin
    strobes = '0;
    nState  = state;
    nTries  = tries;
    unique case (state)
      SNAP_IDLE: begin
        if (snapReq) begin
          strobes.capHi = 1'b1;
          nTries        = '0;
          nState        = SNAP_LO;
        end
      end
      SNAP_LO: begin
        strobes.capLo = 1'b1;
        nState        = SNAP_HI;
      end
      SNAP_HI: begin
        if (hiMatch) begin
          strobes.finish = 1'b1;
          nState         = SNAP_IDLE;
        end else begin
          strobes.capHi = 1'b1;
          if (tries == LAST_TRY) begin
            strobes.finish = 1'b1;
            strobes.warn   = 1'b1;
            nState         = SNAP_IDLE;
          end else begin
            nTries = tries + TRY_W'(1);
            nState = SNAP_LO;
          end
        end
      end
      default: nState = SNAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SNAP_IDLE;
      tries <= '0;
    end else begin
      state <= nState;
      tries <= nTries;
    end
  end
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter
  import stamp_pkg::*;
#(
  parameter int unsigned CNT_W     = 64,
  parameter int unsigned MAX_TRIES = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 usTick,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [CNT_W/2-1:0]   regWrData,
  output logic [CNT_W/2-1:0]   regRdData,
  input  logic                 jumpEn,
  input  logic [CNT_W-1:0]     jumpValue,
  input  logic                 snapReq,
  output logic [CNT_W-1:0]     snapData,
  output logic                 snapValid,
  output logic                 snapWarn
);
  snap_strobe_t     strobes;
  logic             hiMatch;
  logic [CNT_W-1:0] cntNow;

  stamp_ctrl #(.MAX_TRIES(MAX_TRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .snapReq(snapReq), .hiMatch(hiMatch), .strobes(strobes)
  );

  stamp_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .jumpEn(jumpEn), .jumpValue(jumpValue),
    .strobes(strobes), .hiMatch(hiMatch), .cntNow(cntNow), .regRdData(regRdData),
    .snapData(snapData), .snapValid(snapValid), .snapWarn(snapWarn)
  );
endmodule

// File: rtl/stamp_chk.sv
module stamp_chk
  import stamp_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               usTick,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [CNT_W/2-1:0] regWrData,
  input logic               jumpEn,
  input logic [CNT_W-1:0]   jumpValue,
  input logic               snapValid,
  input logic               snapWarn,
  input logic [CNT_W-1:0]   cntNow
);
  localparam int unsigned WORD_W = CNT_W / 2;

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(usTick && !jumpEn && !regWrEn)) |-> cntNow == $past(cntNow) + CNT_W'(1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(!usTick && !jumpEn && !regWrEn)) |-> $stable(cntNow)); // R2
  AST_LO_STAGED: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(regWrEn && regAddr == ADDR_LO && !jumpEn && !usTick)) |-> $stable(cntNow)); // R3
  AST_HI_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(regWrEn && regAddr == ADDR_HI && !jumpEn)) |-> cntNow[CNT_W-1:WORD_W] == $past(regWrData)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(regWrEn && regAddr == ADDR_CTL && regWrData[0] && !jumpEn)) |-> cntNow == '0); // R4
  AST_JUMP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(jumpEn)) |-> cntNow == $past(jumpValue)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    snapValid |=> !snapValid); // R11
  AST_WARN_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    snapWarn |-> snapValid); // R11
endmodule

bind stamp_counter stamp_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .usTick(usTick), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .jumpEn(jumpEn), .jumpValue(jumpValue),
  .snapValid(snapValid), .snapWarn(snapWarn), .cntNow(cntNow)
);

// File: tb/stamp_counter_tb_top.sv
`timescale 1ns/1ps
module stamp_counter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        usTick = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0, jumpEn = 1'b0, snapReq = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [63:0] jumpValue = '0;
  logic [31:0] regRdData;
  logic [63:0] snapData;
  logic        snapValid, snapWarn;

  always #2.5 clk = ~clk;

  stamp_counter dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .jumpEn(jumpEn), .jumpValue(jumpValue), .snapReq(snapReq),
    .snapData(snapData), .snapValid(snapValid), .snapWarn(snapWarn)
  );

  int checks = 0, errors = 0;
  int edgeIdx = 0;
  logic [63:0] mCnt = '0;
  logic [31:0] mShadow = '0;
  logic        mFlag = 1'b0;
  logic [63:0] hist [64];
  logic        histFlag [64];

  bit          snapPending = 0;
  int          reqEdge = 0;
  logic [63:0] lastData = '0;
  bit          lastWarn = 0;
  int          lastLat = 0;

  // reference model: value seen at each edge, then next value
  always @(posedge clk) begin
    hist[edgeIdx % 64]     = mCnt;
    histFlag[edgeIdx % 64] = mFlag;
    if (!rstN) begin
      mCnt = '0; mShadow = '0; mFlag = 1'b0;
    end else begin
      if (jumpEn) mCnt = jumpValue;
      else if (regWrEn && regAddr == 2'd1) mCnt = {regWrData, mShadow};
      else if (regWrEn && regAddr == 2'd2 && regWrData[0]) mCnt = '0;
      else if (usTick) mCnt = mCnt + 64'd1;
      if (regWrEn && regAddr == 2'd0) mShadow = regWrData;
      if (regWrEn && regAddr == 2'd2 && regWrData[0]) mFlag = ~mFlag;
    end
    edgeIdx++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // retry algorithm over the recorded history
  function automatic void expSnap(input int e0, output logic [63:0] d, output bit w, output int lat);
    logic [31:0] hiA, lo, hi2;
    int e;
    hiA = hist[e0 % 64][63:32];
    e = e0 + 1;
    lo = '0; hi2 = '0;
    for (int it = 0; it < 10; it++) begin
      lo  = hist[e % 64][31:0];
      hi2 = hist[(e + 1) % 64][63:32];
      if (hi2 == hiA) begin
        d = {hi2, lo}; w = 0; lat = e - e0 + 2;
        return;
      end
      hiA = hi2;
      e += 2;
    end
    d = {hi2, lo}; w = 1; lat = e - e0;
  endfunction

  task automatic tick();
    bit          rdWas = regRdEn;
    logic [1:0]  rdA = regAddr;
    int          rdE = edgeIdx;
    logic [63:0] hv, expRd, d;
    bit          w;
    int          lat;
    @(posedge clk);
    @(negedge clk);
    if (rdWas) begin
      hv = hist[rdE % 64];
      case (rdA)
        2'd0: expRd = {32'd0, hv[31:0]};
        2'd1: expRd = {32'd0, hv[63:32]};
        2'd2: expRd = {63'd0, histFlag[rdE % 64]};
        default: expRd = '0;
      endcase
      chk(regRdData == expRd[31:0], "R6 word read", {32'd0, regRdData}, expRd);
    end
    if (snapValid) begin
      if (!snapPending) begin
        chk(0, "R10 unexpected snapshot result", 64'd1, 64'd0);
      end else begin
        expSnap(reqEdge, d, w, lat);
        lastData = snapData; lastWarn = snapWarn; lastLat = edgeIdx - reqEdge;
        chk(snapData == d, "R7 snapshot data", snapData, d);
        chk(snapWarn == w, "R9 warn flag", {63'd0, snapWarn}, {63'd0, w});
        chk(lastLat == lat, "R8 snapshot latency", 64'(lastLat), 64'(lat));
        snapPending = 0;
      end
    end else if (snapPending && (edgeIdx - reqEdge > 30)) begin
      chk(0, "R9 snapshot never finished", 64'(edgeIdx - reqEdge), 64'd21);
      snapPending = 0;
    end
    usTick = 0; regWrEn = 0; regRdEn = 0; jumpEn = 0; snapReq = 0;
  endtask

  task automatic reqSnap();
    if (!snapPending) begin
      snapReq = 1; snapPending = 1; reqEdge = edgeIdx;
    end
  endtask

  task automatic waitSnap();
    for (int i = 0; i < 40 && snapPending; i++) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    regWrEn = 1; regAddr = a; regWrData = v; tick();
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] expC, input string tag);
    regRdEn = 1; regAddr = a; tick();
    chk(regRdData == expC, tag, {32'd0, regRdData}, {32'd0, expC});
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    chk(!snapValid && !snapWarn, "R1 snapshot outputs idle", {62'd0, snapValid, snapWarn}, 64'd0);
    chk(regRdData == 0, "R1 read data zero", {32'd0, regRdData}, 64'd0);
    rd(2'd0, 32'd0, "R1 counter low zero");
    rd(2'd1, 32'd0, "R1 counter high zero");
    rd(2'd2, 32'd0, "R1 request flag zero");

    // R3 staged lower write, commit on upper write
    wr(2'd0, 32'hFFFF_FFFD);
    rd(2'd0, 32'd0, "R3 lower write staged only");
    wr(2'd1, 32'h1234_0000);
    rd(2'd0, 32'hFFFF_FFFD, "R3 commit lower");
    rd(2'd1, 32'h1234_0000, "R3 commit upper");

    // R2 carry across words
    repeat (5) begin usTick = 1; tick(); end
    rd(2'd0, 32'h0000_0002, "R2 carry low");
    rd(2'd1, 32'h1234_0001, "R2 carry high");

    // R7 quiet snapshot
    reqSnap(); waitSnap();
    chk(lastData == 64'h1234_0001_0000_0002, "R7 quiet snapshot", lastData, 64'h1234_0001_0000_0002);
    chk(lastLat == 3, "R7 three-read latency", 64'(lastLat), 64'd3);

    // R8 carry during snapshot
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0000_0005);
    reqSnap();
    for (int i = 0; i < 12 && snapPending; i++) begin usTick = 1; tick(); end
    chk(lastData == 64'h0000_0006_0000_0002, "R8 retry data", lastData, 64'h0000_0006_0000_0002);
    chk(lastLat == 5 && !lastWarn, "R8 one retry", 64'(lastLat), 64'd5);

    // R9 and R10: jump every cycle, second request mid-flight
    for (int k = 0; k < 25; k++) begin
      jumpEn = 1; jumpValue = {32'(100 + k), 32'h55};
      if (k == 0) reqSnap();
      if (k == 4) snapReq = 1;
      tick();
    end
    chk(lastWarn == 1, "R9 bound warn", {63'd0, lastWarn}, 64'd1);
    chk(lastData == 64'h0000_0077_0000_0055, "R9 bound data", lastData, 64'h0000_0077_0000_0055);
    chk(lastLat == 21, "R9 bound latency", 64'(lastLat), 64'd21);
    repeat (5) tick();

    // R4 reset toggle
    wr(2'd2, 32'd1);
    rd(2'd2, 32'd1, "R4 flag set");
    rd(2'd0, 32'd0, "R4 counter cleared");
    wr(2'd1, 32'h0000_0009);
    wr(2'd2, 32'd0);
    rd(2'd1, 32'h0000_0009, "R4 bit clear write ignored");
    rd(2'd2, 32'd1, "R4 flag kept");
    wr(2'd2, 32'd1);
    rd(2'd2, 32'd0, "R4 second write clears flag");

    // R5 jump priority
    jumpEn = 1; jumpValue = 64'hAAAA_0000_BBBB_0000; regWrEn = 1; regAddr = 2'd1; regWrData = 32'h1;
    tick();
    rd(2'd1, 32'hAAAA_0000, "R5 jump over load");
    jumpEn = 1; jumpValue = 64'h0000_0003_0000_0004; usTick = 1; regWrEn = 1; regAddr = 2'd2; regWrData = 32'h1;
    tick();
    rd(2'd0, 32'h0000_0004, "R5 jump over clear");
    rd(2'd3, 32'd0, "R6 unused address");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      usTick = ($urandom % 4) != 0;
      if ($urandom % 16 == 0) begin
        jumpEn = 1;
        jumpValue = {mCnt[63:32] + 32'($urandom % 2), $urandom};
      end
      if ($urandom % 64 == 0) begin
        regWrEn = 1; regAddr = 2'($urandom % 3); regWrData = $urandom;
      end else if ($urandom % 4 == 0) begin
        regRdEn = 1; regAddr = 2'($urandom % 4);
      end
      if ($urandom % 3 == 0) reqSnap();
      else if ($urandom % 5 == 0) snapReq = 1; // ignored if busy, R10
      if (snapReq && !snapPending) snapReq = 0;
      tick();
    end
    waitSnap();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule